// File: doc/BRIEF.md
# Output Pin Latch Port with Atomic Bit Update

This block is a 32-pin general-purpose output port. Every pin owns one output data latch. Software can change the latches in two ways. The first is a whole-word load through a data register. The second is three write-only alias registers that set, clear or invert only the bits written as 1. The aliases let one bus write change a few pins without a read-modify-write sequence, so other agents sharing the port cannot lose an update.

A direction register picks, pin by pin, whether the latch value is driven. `pin_oe` carries the direction bits and `pin_out` carries the latch values; a pad with `pin_oe` low stays high impedance. The latch takes an update even while its pin is an input, so software can preload a level before turning the pin into an output.

The bus is a plain strobe interface. It has no back-pressure: a write is always accepted at the clock edge on which `bus_wr` is high, and read data is returned combinationally in the cycle where `bus_rd` is high. Only one write can occur per cycle, so the alias operations never collide.

Top module: `gpo_port_latch`

## Requirements
- R1: After reset every latch is 0 and every direction bit is 0, so `pin_out` and `pin_oe` are all zero.
- R2: A write to word address 0 (data register) loads all latches from `bus_wdata` at the next clock edge, and a read of address 0 returns the current latch values.
- R3: A write to word address 1 (direction register) takes effect at the next clock edge. A 1 bit marks that pin as an output, and `pin_oe` equals the direction register. A read of address 1 returns the register.
- R4: A write to word address 2 (set alias) drives to 1 every latch whose `bus_wdata` bit is 1 and leaves the other latches unchanged.
- R5: A write to word address 3 (clear alias) drives to 0 every latch whose `bus_wdata` bit is 1 and leaves the other latches unchanged.
- R6: A write to word address 4 (toggle alias) inverts every latch whose `bus_wdata` bit is 1 and leaves the other latches unchanged.
- R7: A read of addresses 2, 3 or 4 always returns zero.
- R8: Alias and data writes update a latch whose pin is an input, and they leave that pin's `pin_oe` low.
- R9: `pin_out` always equals the latch values, so an output-enabled pin follows its latch.
- R10: A write to an address from 5 upward changes no latch and no direction bit, and a read of such an address returns zero.
- R11: Bit i of `bus_wdata` in the alias registers acts only on pin i, with bit 0 as the lowest pin.
- R12: `bus_rdata` is zero in any cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | PINS (32) | Write data |
| bus_rdata | output | PINS (32) | Read data, combinational |
| pin_out | output | PINS (32) | Latch value per pin |
| pin_oe | output | PINS (32) | Output enable per pin |

## Verification
A wrong latch bit appears on `pin_out` one clock edge after the write that corrupted it, and on `bus_rdata` in the same cycle as the next data-register read. The bench therefore compares both outputs against its model after every operation. A direction fault appears immediately on `pin_oe`. A decode fault, such as an alias that leaks into a neighbour bit or an address that aliases another register, shows up as a mismatch on the first write that touches the affected bits. Random masks over hundreds of operations expose these faults quickly.

// File: rtl/gpo_latch_pkg.sv
package gpo_latch_pkg;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned REG_COUNT = 5;

  localparam logic [REG_IDX_W-1:0] IDX_DATA = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_DIR  = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_SET  = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CLR  = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_TGL  = 3'd4;

  typedef struct packed {
    logic load;
    logic dir;
    logic set;
    logic clr;
    logic tgl;
  } wr_sel_t;
endpackage

// File: rtl/gpo_addr_decode.sv
module gpo_addr_decode
  import gpo_latch_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              mapped,
  output logic [REG_IDX_W-1:0] idx,
  output wr_sel_t           wsel
);
  always_comb begin
    mapped = (int'(bus_addr) < int'(REG_COUNT));
    idx    = REG_IDX_W'(bus_addr);
    wsel   = '0;
    if (bus_wr && mapped) begin
      unique case (idx)
        IDX_DATA: wsel.load = 1'b1;
        IDX_DIR:  wsel.dir  = 1'b1;
        IDX_SET:  wsel.set  = 1'b1;
        IDX_CLR:  wsel.clr  = 1'b1;
        IDX_TGL:  wsel.tgl  = 1'b1;
        default:  wsel      = '0;
      endcase
    end
  end

  // R10
  sel_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));

  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (wsel == '0));
endmodule

// File: rtl/gpo_latch_bank.sv
module gpo_latch_bank
  import gpo_latch_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wr_sel_t         wsel,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] q
);
  logic [PINS-1:0] nxt;

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    always_comb begin
      nxt[i] = q[i];
      if (wsel.load)                nxt[i] = wdata[i];
      else if (wsel.set && wdata[i]) nxt[i] = 1'b1;
      else if (wsel.clr && wdata[i]) nxt[i] = 1'b0;
      else if (wsel.tgl && wdata[i]) nxt[i] = ~q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R4
  set_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.set |=> (((q & $past(wdata)) == $past(wdata)) &&
                  ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

  // R5
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.clr |=> (((q & $past(wdata)) == '0) &&
                  ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

  // R6
  tgl_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.tgl |=> ((q ^ $past(q)) == $past(wdata)));

  // R2
  load_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.load |=> (q == $past(wdata)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wsel.load || wsel.set || wsel.clr || wsel.tgl) |=> $stable(q));
endmodule

// File: rtl/gpo_dir_reg.sv
module gpo_dir_reg #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dir <= '0;
    else if (we) dir <= wdata;
  end

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(dir));
endmodule

// File: rtl/gpo_read_mux.sv
module gpo_read_mux
  import gpo_latch_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic                 rd,
  input  logic                 mapped,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [PINS-1:0]      latch,
  input  logic [PINS-1:0]      dir,
  output logic [PINS-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    if (rd && mapped) begin
      case (idx)
        IDX_DATA: rdata = latch;
        IDX_DIR:  rdata = dir;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpo_port_latch.sv
module gpo_port_latch
  import gpo_latch_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  logic                 mapped;
  logic [REG_IDX_W-1:0] idx;
  wr_sel_t              wsel;
  logic [PINS-1:0]      latch_q;
  logic [PINS-1:0]      dir_q;

  gpo_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .mapped(mapped), .idx(idx), .wsel(wsel)
  );

  gpo_latch_bank #(.PINS(PINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .wdata(bus_wdata), .q(latch_q)
  );

  gpo_dir_reg #(.PINS(PINS)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(wsel.dir), .wdata(bus_wdata), .dir(dir_q)
  );

  gpo_read_mux #(.PINS(PINS)) u_rmux (
    .rd(bus_rd), .mapped(mapped), .idx(idx),
    .latch(latch_q), .dir(dir_q), .rdata(bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;

  // R7
  alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (int'(bus_addr) >= 2) && (int'(bus_addr) <= 4)) |-> (bus_rdata == '0));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (int'(bus_addr) >= int'(REG_COUNT))) |-> (bus_rdata == '0));

  // R12
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  // R8
  oe_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (int'(bus_addr) != 1)) |=> $stable(pin_oe));
endmodule

// File: tb/tb_gpo_port_latch.sv
module tb_gpo_port_latch;
  localparam int unsigned PINS   = 32;
  localparam int unsigned ADDR_W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [PINS-1:0]   bus_wdata = '0;
  logic [PINS-1:0]   bus_rdata;
  logic [PINS-1:0]   pin_out;
  logic [PINS-1:0]   pin_oe;

  int checks = 0;
  int fails  = 0;
  logic [PINS-1:0] m_lat = '0;
  logic [PINS-1:0] m_dir = '0;

  gpo_port_latch #(.PINS(PINS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] model_next(int a, logic [PINS-1:0] cur,
                                                 logic [PINS-1:0] d);
    case (a)
      0: return d;
      2: return cur | d;
      3: return cur & ~d;
      4: return cur ^ d;
      default: return cur;
    endcase
  endfunction

  function automatic logic [PINS-1:0] model_read(int a);
    case (a)
      0: return m_lat;
      1: return m_dir;
      default: return '0;
    endcase
  endfunction

  task automatic bus_write(int a, logic [PINS-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    m_lat = model_next(a, m_lat, d);
    if (a == 1) m_dir = d;
  endtask

  task automatic bus_read(int a, string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    #1;
    check(req, bus_rdata, model_read(a));
    bus_rd = 1'b0;
  endtask

  task automatic check_pins(string req);
    #1;
    check({req, " R9 pin_out"}, pin_out, m_lat);
    check({req, " R3 pin_oe"}, pin_oe, m_dir);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    rst_n = 1'b1;
    bus_read(0, "R1 data read");
    bus_read(1, "R1 dir read");
    // R12 no read strobe
    #1 check("R12 idle rdata", bus_rdata, '0);

    // R8 alias on input pins: latch moves, oe stays low
    bus_write(2, 32'h0000_00F0);
    check_pins("R8 set while input");
    bus_read(0, "R8 data after set");
    bus_write(4, 32'h0000_0030);
    check_pins("R8 toggle while input");
    // R2 data load
    bus_write(0, 32'hA5A5_5A5A);
    check_pins("R2 load");
    bus_read(0, "R2 readback");
    // R3 direction
    bus_write(1, 32'hFFFF_0000);
    check_pins("R3 dir");
    bus_read(1, "R3 dir readback");
    // R11 single-bit corners
    bus_write(2, 32'h0000_0001);
    check_pins("R11 set bit0");
    bus_write(3, 32'h8000_0000);
    check_pins("R11 clr bit31");
    bus_write(4, 32'h8000_0001);
    check_pins("R11 tgl ends");
    // R4 R5 R6 zero writes have no effect
    bus_write(2, '0); check_pins("R4 zero set");
    bus_write(3, '0); check_pins("R5 zero clr");
    bus_write(4, '0); check_pins("R6 zero tgl");
    // R7 alias reads
    bus_read(2, "R7 set reads zero");
    bus_read(3, "R7 clr reads zero");
    bus_read(4, "R7 tgl reads zero");
    // R10 unmapped
    bus_write(5, 32'hFFFF_FFFF);
    check_pins("R10 write addr5");
    bus_write(15, 32'h1234_5678);
    check_pins("R10 write addr15");
    bus_read(7, "R10 read unmapped");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int a;
      logic [PINS-1:0] d;
      a = int'($urandom % 7);
      if (a == 6) a = 9;
      d = $urandom;
      if ($urandom % 4 == 0) d = PINS'(1) << ($urandom % PINS);
      if ($urandom % 3 == 0) begin
        bus_read(a, "R2 R7 R10 random read");
      end else begin
        bus_write(a, d);
        check_pins("R4 R5 R6 random write");
      end
    end
    bus_read(0, "R2 final data");
    bus_read(1, "R3 final dir");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule